// File: doc/BRIEF.md
# Transition-Coded Off-Chip Bus Codec

This block sends narrow data words across a wider off-chip bus so that every change of the pin vector is one of a known set of allowed steps. The set is chosen so that package inductance does not cause supply bounce or glitches. The bus is split into identical segments of `SEG_W` pins. Each segment carries a `DATA_W`-bit word, with `DATA_W` below `SEG_W`.

The transmit side of each segment stores the vector it drives now. For each accepted word it looks up the next vector in a shared step table, using the pair (current vector, word) as the index. The receive side stores the vector it saw last. It recovers the word by searching that vector's row of the same table for the vector now arriving.

Transmitter and receiver start from an agreed vector after reset. The table holds a computed default after reset. Any entry can be overwritten through a write port. Entry (v, d) of the default table is v XOR (d shifted left by `SEG_W-DATA_W`). Idle cycles keep the bus vector unchanged, and this step is always allowed.

Top module: `xtc_bus_codec`

## Requirements
- R1: During and after reset, every segment of `bus_vec` equals `INIT_VEC`, `rx_out_valid` is 0 and `tx_ready` is 1.
- R2: When `tx_valid` and `tx_ready` are both high at a rising edge, after that edge each segment s of `bus_vec` (bits `[s*SEG_W +: SEG_W]`) equals the table entry for (its previous vector, `tx_data[s*DATA_W +: DATA_W]`).
- R3: On a cycle with no accepted word, `bus_vec` keeps its value.
- R4: `tx_ready` is 0 in every cycle where `tbl_we` is 1, and a word offered in such a cycle leaves `bus_vec` unchanged.
- R5: A table write with `tbl_we` high replaces entry (`tbl_cur`, `tbl_word`) with `tbl_next`, and both sides use the new entry from the next cycle on.
- R6: When `rx_valid` is high at an edge, after that edge `rx_out_valid` is 1 and each segment of `rx_out_data` holds the word d whose entry (previous received vector, d) equals that segment of `rx_vec`. With no `rx_valid`, `rx_out_valid` is 0 after the edge.
- R7: If no entry in the row matches, the segment's bit of `rx_bad` is 1 and its word is 0. The received vector still becomes that segment's previous vector.
- R8: If several words in a row map to the received vector, the lowest word wins.
- R9: Segments are independent. Each one steps only along entries of its own current row, so each emitted step is listed in the table.
- R10: After reset, table entry (v, d) holds v XOR (d << (`SEG_W-DATA_W`)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_cur | input | SEG_W | Row (source vector) of the entry written |
| tbl_word | input | DATA_W | Column (data word) of the entry written |
| tbl_next | input | SEG_W | Destination vector stored |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit word can be taken |
| tx_data | input | NUM_SEG*DATA_W | Words, one per segment |
| bus_vec | output | NUM_SEG*SEG_W | Driven physical vector |
| rx_valid | input | 1 | Received vector present |
| rx_vec | input | NUM_SEG*SEG_W | Received physical vector |
| rx_out_valid | output | 1 | Decoded word valid |
| rx_out_data | output | NUM_SEG*DATA_W | Decoded words |
| rx_bad | output | NUM_SEG | Per-segment step not found in table |

## Verification
The assertions assume that table writes and received beats arrive only while the block is out of reset. They also assume that `rx_vec` is stable around the clock edge. They do not assume that rows are free of duplicates or that received steps are allowed. Those cases are defined behaviour, covered by R7 and R8. The stimulus changes every input on the falling edge. The bench loads a duplicate entry and an unlisted step on purpose, and only after it has checked the round trip on clean tables.

// File: rtl/xtc_pkg.sv
`timescale 1ns/1ps
package xtc_pkg;
   // default step table entry: toggle the upper bits by the data word
   function automatic logic [31:0] xtc_default_step(input logic [31:0] vec,
                                                    input logic [31:0] word,
                                                    input int unsigned shift);
      return vec ^ (word << shift);
   endfunction
endpackage

// File: rtl/xtc_step_table.sv
`timescale 1ns/1ps
module xtc_step_table #(
   parameter int SEG_W  = 4,
   parameter int DATA_W = 2
) (
   input  logic                                      clk,
   input  logic                                      rst_n,
   input  logic                                      wr_en,
   input  logic [SEG_W-1:0]                          wr_cur,
   input  logic [DATA_W-1:0]                         wr_word,
   input  logic [SEG_W-1:0]                          wr_next,
   output logic [(1<<(SEG_W+DATA_W))*SEG_W-1:0]      tab_flat
);
   localparam int COLS    = 1 << DATA_W;
   localparam int IDX_W   = SEG_W + DATA_W;
   localparam int ENTRIES = 1 << IDX_W;

   logic [SEG_W-1:0] ent_q [ENTRIES];
   logic [IDX_W-1:0] wr_idx;
   assign wr_idx = {wr_cur, wr_word};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < ENTRIES; e++)
            ent_q[e] <= SEG_W'(xtc_pkg::xtc_default_step(32'(e / COLS), 32'(e % COLS),
                                                        SEG_W - DATA_W));
      end else if (wr_en) begin
         ent_q[wr_idx] <= wr_next;
      end
   end

   for (genvar e = 0; e < ENTRIES; e++) begin : g_flat
      assign tab_flat[e*SEG_W +: SEG_W] = ent_q[e];
   end

   AST_TABLE_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (ent_q[$past(wr_idx)] == $past(wr_next))); // R5
endmodule

// File: rtl/xtc_enc_lane.sv
`timescale 1ns/1ps
module xtc_enc_lane #(
   parameter int SEG_W    = 4,
   parameter int DATA_W   = 2,
   parameter int INIT_VEC = 0
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic [(1<<(SEG_W+DATA_W))*SEG_W-1:0]  tab_flat,
   input  logic                                  beat,
   input  logic [DATA_W-1:0]                     word,
   output logic [SEG_W-1:0]                      vec
);
   localparam int IDX_W = SEG_W + DATA_W;

   logic [SEG_W-1:0] cur_q;
   logic [IDX_W-1:0] idx;
   logic [SEG_W-1:0] nxt;

   assign idx = {cur_q, word};
   assign nxt = tab_flat[int'(idx)*SEG_W +: SEG_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cur_q <= SEG_W'(INIT_VEC);
      else if (beat) cur_q <= nxt;
   end

   assign vec = cur_q;

   AST_IDLE_HOLDS_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
      !beat |=> $stable(vec)); // R3
endmodule

// File: rtl/xtc_dec_lane.sv
`timescale 1ns/1ps
module xtc_dec_lane #(
   parameter int SEG_W    = 4,
   parameter int DATA_W   = 2,
   parameter int INIT_VEC = 0
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic [(1<<(SEG_W+DATA_W))*SEG_W-1:0]  tab_flat,
   input  logic                                  rx_beat,
   input  logic [SEG_W-1:0]                      rx_seg,
   output logic                                  dec_valid,
   output logic [DATA_W-1:0]                     dec_word,
   output logic                                  dec_bad
);
   localparam int COLS = 1 << DATA_W;

   logic [SEG_W-1:0]  prev_q;
   logic [COLS-1:0]   hit;
   logic [DATA_W-1:0] word_c;
   logic              found_c;

   for (genvar c = 0; c < COLS; c++) begin : g_cmp
      assign hit[c] = (tab_flat[(int'(prev_q)*COLS + c)*SEG_W +: SEG_W] == rx_seg);
   end

   // descending scan so the lowest matching word is kept
   always_comb begin
      word_c  = '0;
      found_c = 1'b0;
      for (int c = COLS-1; c >= 0; c--) begin
         if (hit[c]) begin
            word_c  = DATA_W'(c);
            found_c = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q    <= SEG_W'(INIT_VEC);
         dec_valid <= 1'b0;
         dec_word  <= '0;
         dec_bad   <= 1'b0;
      end else begin
         dec_valid <= rx_beat;
         if (rx_beat) begin
            prev_q   <= rx_seg;
            dec_word <= word_c;
            dec_bad  <= !found_c;
         end
      end
   end

   AST_VALID_FOLLOWS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (dec_valid == $past(rx_beat))); // R6
   AST_PREV_TRACKS_RX: assert property (@(posedge clk) disable iff (!rst_n)
      rx_beat |=> (prev_q == $past(rx_seg))); // R7
   AST_BAD_CLEARS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && dec_bad) |-> (dec_word == '0)); // R7
endmodule

// File: rtl/xtc_bus_codec.sv
`timescale 1ns/1ps
module xtc_bus_codec #(
   parameter int SEG_W    = 4,
   parameter int DATA_W   = 2,
   parameter int NUM_SEG  = 3,
   parameter int INIT_VEC = 0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        tbl_we,
   input  logic [SEG_W-1:0]            tbl_cur,
   input  logic [DATA_W-1:0]           tbl_word,
   input  logic [SEG_W-1:0]            tbl_next,
   input  logic                        tx_valid,
   output logic                        tx_ready,
   input  logic [NUM_SEG*DATA_W-1:0]   tx_data,
   output logic [NUM_SEG*SEG_W-1:0]    bus_vec,
   input  logic                        rx_valid,
   input  logic [NUM_SEG*SEG_W-1:0]    rx_vec,
   output logic                        rx_out_valid,
   output logic [NUM_SEG*DATA_W-1:0]   rx_out_data,
   output logic [NUM_SEG-1:0]          rx_bad
);
   localparam int TAB_BITS = (1 << (SEG_W + DATA_W)) * SEG_W;

   if (DATA_W >= SEG_W) begin : g_bad_width
      $error("xtc_bus_codec: DATA_W must be below SEG_W");
   end
   if (NUM_SEG < 1) begin : g_bad_count
      $error("xtc_bus_codec: NUM_SEG must be at least 1");
   end
   if (INIT_VEC < 0 || INIT_VEC >= (1 << SEG_W)) begin : g_bad_init
      $error("xtc_bus_codec: INIT_VEC out of range");
   end

   logic [TAB_BITS-1:0] tab_flat;
   logic                beat;
   logic [NUM_SEG-1:0]  lane_valid;

   assign tx_ready = !tbl_we;
   assign beat     = tx_valid && tx_ready;

   xtc_step_table #(.SEG_W(SEG_W), .DATA_W(DATA_W)) i_table (
      .clk(clk), .rst_n(rst_n), .wr_en(tbl_we), .wr_cur(tbl_cur),
      .wr_word(tbl_word), .wr_next(tbl_next), .tab_flat(tab_flat));

   for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
      xtc_enc_lane #(.SEG_W(SEG_W), .DATA_W(DATA_W), .INIT_VEC(INIT_VEC)) i_enc (
         .clk(clk), .rst_n(rst_n), .tab_flat(tab_flat), .beat(beat),
         .word(tx_data[s*DATA_W +: DATA_W]), .vec(bus_vec[s*SEG_W +: SEG_W]));
      xtc_dec_lane #(.SEG_W(SEG_W), .DATA_W(DATA_W), .INIT_VEC(INIT_VEC)) i_dec (
         .clk(clk), .rst_n(rst_n), .tab_flat(tab_flat), .rx_beat(rx_valid),
         .rx_seg(rx_vec[s*SEG_W +: SEG_W]), .dec_valid(lane_valid[s]),
         .dec_word(rx_out_data[s*DATA_W +: DATA_W]), .dec_bad(rx_bad[s]));
   end

   assign rx_out_valid = &lane_valid;

   AST_LOAD_BLOCKS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (tbl_we && tx_valid) |=> $stable(bus_vec)); // R4
endmodule

// File: tb/test_xtc_bus_codec.sv
`timescale 1ns/1ps
module test_xtc_bus_codec;
   localparam int SW = 4;
   localparam int DW = 2;
   localparam int NS = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tbl_we = 1'b0;
   logic [SW-1:0] tbl_cur = '0;
   logic [DW-1:0] tbl_word = '0;
   logic [SW-1:0] tbl_next = '0;
   logic tx_valid = 1'b0;
   logic tx_ready;
   logic [NS*DW-1:0] tx_data = '0;
   logic [NS*SW-1:0] bus_vec;
   logic rx_valid = 1'b0;
   logic [NS*SW-1:0] rx_vec = '0;
   logic rx_out_valid;
   logic [NS*DW-1:0] rx_out_data;
   logic [NS-1:0] rx_bad;

   int checks = 0;
   int failures = 0;
   int tab_m [16][4];
   int enc_m [NS];
   logic [15:0] lfsr = 16'hACE1;

   always #5 clk = ~clk;

   xtc_bus_codec #(.SEG_W(SW), .DATA_W(DW), .NUM_SEG(NS), .INIT_VEC(0)) i_xtc_bus_codec (
      .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_cur(tbl_cur), .tbl_word(tbl_word),
      .tbl_next(tbl_next), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
      .bus_vec(bus_vec), .rx_valid(rx_valid), .rx_vec(rx_vec), .rx_out_valid(rx_out_valid),
      .rx_out_data(rx_out_data), .rx_bad(rx_bad));

   // bit 6: 1 = offer word, 0 = idle cycle; bits 5:0 = words for segments 2..0
   localparam logic [6:0] STIM [12] = '{
      7'h40, 7'h41, 7'h4E, 7'h00, 7'h7F, 7'h55, 7'h00, 7'h6A, 7'h43, 7'h7C, 7'h00, 7'h59 };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [NS*SW-1:0] model_bus();
      logic [NS*SW-1:0] b;
      for (int s = 0; s < NS; s++) b[s*SW +: SW] = SW'(enc_m[s]);
      return b;
   endfunction

   task automatic send_beat(input logic [NS*DW-1:0] d);
      int old [NS];
      for (int s = 0; s < NS; s++) old[s] = enc_m[s];
      @(negedge clk);
      tx_valid = 1'b1;
      tx_data  = d;
      @(negedge clk);
      tx_valid = 1'b0;
      for (int s = 0; s < NS; s++) enc_m[s] = tab_m[old[s]][int'(d[s*DW +: DW])];
      check(bus_vec == model_bus(), "R2 R10 next vector", int'(bus_vec), int'(model_bus()));
      for (int s = 0; s < NS; s++) begin
         bit legal = 1'b0;
         for (int c = 0; c < 4; c++)
            if (tab_m[old[s]][c] == int'(bus_vec[s*SW +: SW])) legal = 1'b1;
         check(legal, "R9 step listed", int'(bus_vec[s*SW +: SW]), old[s]);
      end
      rx_valid = 1'b1;
      rx_vec   = bus_vec;
      @(negedge clk);
      rx_valid = 1'b0;
      check(rx_out_valid == 1'b1, "R6 out valid", int'(rx_out_valid), 1);
      check(rx_out_data == d && rx_bad == '0, "R6 decoded word", int'(rx_out_data), int'(d));
   endtask

   initial begin
      #(200000 * 10);
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int v = 0; v < 16; v++)
         for (int d = 0; d < 4; d++) tab_m[v][d] = v ^ (d << (SW - DW));
      for (int s = 0; s < NS; s++) enc_m[s] = 0;

      repeat (3) @(negedge clk);
      check(bus_vec == '0 && rx_out_valid == 1'b0, "R1 in reset", int'(bus_vec), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(bus_vec == '0 && rx_out_valid == 1'b0 && tx_ready == 1'b1,
            "R1 after reset", int'(bus_vec), 0);

      // default table walk
      for (int i = 0; i < 12; i++) begin
         if (STIM[i][6]) begin
            send_beat(STIM[i][5:0]);
         end else begin
            logic [NS*SW-1:0] held;
            held = bus_vec;
            @(negedge clk);
            check(bus_vec == held, "R3 idle holds", int'(bus_vec), int'(held));
            check(rx_out_valid == 1'b0, "R6 no beat no valid", int'(rx_out_valid), 0);
         end
      end

      // load a different table while a word is offered
      begin
         logic [NS*SW-1:0] held;
         held = bus_vec;
         tx_valid = 1'b1;
         tx_data  = '1;
         for (int v = 0; v < 16; v++) begin
            for (int d = 0; d < 4; d++) begin
               tab_m[v][d] = (d == 0) ? v : (v ^ (1 << (d - 1)));
               tbl_we   = 1'b1;
               tbl_cur  = SW'(v);
               tbl_word = DW'(d);
               tbl_next = SW'(tab_m[v][d]);
               if (v == 5 && d == 2)
                  check(tx_ready == 1'b0, "R4 ready low during load", int'(tx_ready), 0);
               @(negedge clk);
            end
         end
         tbl_we   = 1'b0;
         tx_valid = 1'b0;
         check(bus_vec == held, "R4 word not taken during load", int'(bus_vec), int'(held));
      end

      // walk the loaded table with pseudo-random words
      for (int i = 0; i < 40; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         send_beat(lfsr[5:0] ^ lfsr[13:8]);
      end

      // duplicate destination in a row: lowest word wins
      begin
         int p0;
         logic [NS*SW-1:0] inj;
         p0 = enc_m[0];
         @(negedge clk);
         tbl_we = 1'b1; tbl_cur = SW'(p0); tbl_word = 2'd3; tbl_next = SW'(p0 ^ 1);
         @(negedge clk);
         tbl_we = 1'b0;
         tab_m[p0][3] = p0 ^ 1;
         inj = model_bus();
         inj[SW-1:0] = SW'(p0 ^ 1);
         rx_valid = 1'b1; rx_vec = inj;
         @(negedge clk);
         rx_valid = 1'b0;
         check(rx_out_data == 6'b000001 && rx_bad == '0, "R8 lowest word wins",
               int'(rx_out_data), 1);

         // step not in the row of segment 0
         inj[SW-1:0] = SW'((p0 ^ 1) ^ 8);
         rx_valid = 1'b1; rx_vec = inj;
         @(negedge clk);
         rx_valid = 1'b0;
         check(rx_bad == 3'b001, "R7 bad flag", int'(rx_bad), 1);
         check(rx_out_data == '0, "R7 word zero", int'(rx_out_data), 0);

         // same vector again: previous was updated, so this is the self step
         rx_valid = 1'b1; rx_vec = inj;
         @(negedge clk);
         rx_valid = 1'b0;
         check(rx_bad == '0 && rx_out_data == '0, "R7 previous updated",
               int'({rx_bad, rx_out_data}), 0);
      end

      // a table write is used by the encoder on the next beat
      begin
         int c0;
         c0 = enc_m[0];
         @(negedge clk);
         tbl_we = 1'b1; tbl_cur = SW'(c0); tbl_word = 2'd2; tbl_next = SW'(c0 ^ 4'hF);
         @(negedge clk);
         tbl_we = 1'b0;
         tab_m[c0][2] = c0 ^ 15;
         tx_valid = 1'b1; tx_data = 6'b000010;
         @(negedge clk);
         tx_valid = 1'b0;
         check(bus_vec[SW-1:0] == SW'(c0 ^ 15), "R5 new entry used",
               int'(bus_vec[SW-1:0]), c0 ^ 15);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule